// File: doc/BRIEF.md
# Windowed Address Range Checker

This block sits in front of a memory port and checks every read and write request against a table of address windows. Each window has its own enable bit. It is described by two 4 KB page numbers: a lower bound, which is inclusive, and an upper bound, which is exclusive. A request whose page lies inside at least one enabled window is forwarded to memory. A read that matches no enabled window never reaches memory and gets a programmable fill word instead. A write that matches no enabled window is discarded. Either kind of miss sets a sticky error flag, which can raise an interrupt, and captures the first offending address of that kind.

Software programs the table through a single-cycle register port. Enable bits are grouped 32 to a word. Single bits can be set or cleared by window index, so one window can be switched without touching its neighbours. The check is made by a controller that scans one window per cycle and stops at the first match. The controller has these states:

- ST_IDLE: ready for a request. It moves to ST_SCAN on acceptance.
- ST_SCAN: tests the current window. On a match it moves to ST_HIT. When the last window misses it moves to ST_MISS. Otherwise it advances the index and stays.
- ST_HIT: issues the memory access. After a write it moves to ST_RESP; after a read it moves to ST_MEMWAIT.
- ST_MEMWAIT: captures the read data, then moves to ST_RESP.
- ST_MISS: records the event and picks the fill word, then moves to ST_RESP.
- ST_RESP: presents the response for one cycle, then returns to ST_IDLE.

Top module: `addr_window_guard`

## Requirements
- R1: After reset the fill register reads 0x92929292. All enable words read 0. The status register reads 0. irq is 0 and req_ready is 1.
- R2: A request is inside a window when its page number (req_addr >> 12) is greater than or equal to the lower bound and strictly less than the upper bound.
- R3: A disabled window never matches, whatever its bounds.
- R4: The enable bit of window i sits in enable word i >> 5, at bit i mod 32. Writing an enable word replaces all 32 bits; reading it returns them.
- R5: A set command (ctrl index 7) or a clear command (ctrl index 8) carries a window index in reg_wdata. It changes only that window's bit and leaves the other bits of its word unchanged.
- R6: A read that hits issues one memory read (mem_req=1, mem_we=0). Its response has rsp_hit=1 and carries the mem_rdata returned one cycle after mem_req.
- R7: A read that misses issues no memory access. Its response has rsp_hit=0 and rsp_rdata equal to the current fill register. The fill register is writable at ctrl index 0.
- R8: A write that hits is forwarded once (mem_req=1, mem_we=1) with its address and data. A write that misses makes no memory access; its response has rsp_hit=0.
- R9: A read miss sets status bit 0 and a write miss sets status bit 1. The first miss of each kind captures its address. Later misses of that kind leave the captured address unchanged until software writes 1 to that status bit.
- R10: irq is 1 exactly when bit 0 of the irq-enable register (ctrl index 1) is 1 and at least one status bit is set.
- R11: Only one request is in flight. req_ready drops in the cycle after acceptance, and each request produces exactly one single-cycle rsp_valid pulse.
- R12: The register address is {region[1:0], index}. Region 0 holds lower bounds, region 1 upper bounds, region 2 enable words and region 3 control. The control indices are: 0 fill, 1 irq-enable, 2 status (write 1 to clear), 3 and 4 read-miss address low and high, 5 and 6 write-miss address low and high, 7 set bit, 8 clear bit. reg_rdata is valid in the cycle after reg_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | IDX_W+2 | Register address {region, index} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| req_valid | input | 1 | Checked request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Request byte address |
| req_wdata | input | 32 | Request write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_write | output | 1 | Response belongs to a write |
| rsp_hit | output | 1 | Request matched an enabled window |
| rsp_rdata | output | 32 | Read data or fill word |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_req |
| irq | output | 1 | Range-check-fail interrupt |

## Verification
The bench builds the block with NUM_WIN=64 and AW=36. With 64 windows there are two enable words, so a window in the second word (index 40) and the last window (index 63) can both be reached, and a full miss scan stays short. A 36-bit address leaves four bits above bit 31, so the high half of a captured miss address can be checked against a non-zero value.

// File: rtl/awg_pkg.sv
package awg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_HIT,
        ST_MEMWAIT,
        ST_MISS,
        ST_RESP
    } scan_state_e;

    typedef enum logic [1:0] {
        RG_LOWER  = 2'd0,
        RG_UPPER  = 2'd1,
        RG_ENABLE = 2'd2,
        RG_CTRL   = 2'd3
    } reg_region_e;

    localparam int CT_FILL    = 0;
    localparam int CT_IRQEN   = 1;
    localparam int CT_STATUS  = 2;
    localparam int CT_RSRC_LO = 3;
    localparam int CT_RSRC_HI = 4;
    localparam int CT_WSRC_LO = 5;
    localparam int CT_WSRC_HI = 6;
    localparam int CT_SET     = 7;
    localparam int CT_CLR     = 8;

    localparam logic [31:0] FILL_RESET = 32'h9292_9292;

endpackage

// File: rtl/awg_window_table.sv
module awg_window_table #(
    parameter int NUM_WIN = 256,
    parameter int PAGE_W  = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tbl_wr,
    input  logic                       tbl_sel_upper,
    input  logic [$clog2(NUM_WIN)-1:0] tbl_idx,
    input  logic [PAGE_W-1:0]          tbl_wpage,
    input  logic                       en_word_wr,
    input  logic [$clog2(NUM_WIN)-1:0] en_word_idx,
    input  logic [31:0]                en_word_data,
    input  logic                       bit_set,
    input  logic                       bit_clr,
    input  logic [$clog2(NUM_WIN)-1:0] bit_idx,
    input  logic [$clog2(NUM_WIN)-1:0] scan_idx,
    output logic [PAGE_W-1:0]          scan_lo,
    output logic [PAGE_W-1:0]          scan_hi,
    output logic                       scan_en,
    output logic [PAGE_W-1:0]          rd_lo,
    output logic [PAGE_W-1:0]          rd_hi,
    output logic [NUM_WIN-1:0]         en_flat
);
    localparam int NUM_WORDS = NUM_WIN / 32;

    logic [PAGE_W-1:0] lo_q [NUM_WIN];
    logic [PAGE_W-1:0] hi_q [NUM_WIN];
    logic [31:0]       en_q [NUM_WORDS];
    logic [NUM_WIN-1:0] bit_mask;

    always_ff @(posedge clk) begin
        if (tbl_wr && !tbl_sel_upper) lo_q[tbl_idx] <= tbl_wpage;
        if (tbl_wr &&  tbl_sel_upper) hi_q[tbl_idx] <= tbl_wpage;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < NUM_WORDS; w++) en_q[w] <= '0;
        end else begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (en_word_wr && int'(en_word_idx) == w)
                    en_q[w] <= en_word_data;
                else if (bit_set && (int'(bit_idx) >> 5) == w)
                    en_q[w][bit_idx[4:0]] <= 1'b1;
                else if (bit_clr && (int'(bit_idx) >> 5) == w)
                    en_q[w][bit_idx[4:0]] <= 1'b0;
            end
        end
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_flat
        assign en_flat[w*32 +: 32] = en_q[w];
    end

    assign scan_lo  = lo_q[scan_idx];
    assign scan_hi  = hi_q[scan_idx];
    assign scan_en  = en_flat[scan_idx];
    assign rd_lo    = lo_q[tbl_idx];
    assign rd_hi    = hi_q[tbl_idx];
    assign bit_mask = NUM_WIN'(1) << bit_idx;

    AST_BIT_ISOLATION: assert property (@(posedge clk) disable iff (!rst_n)
        ((bit_set || bit_clr) && !en_word_wr) |=>
        (((en_flat ^ $past(en_flat)) & ~$past(bit_mask)) == '0)); // R5

endmodule

// File: rtl/awg_miss_recorder.sv
module awg_miss_recorder #(
    parameter int AW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          miss_pulse,
    input  logic          miss_write,
    input  logic [AW-1:0] miss_addr,
    input  logic [1:0]    clr_mask,
    input  logic          irq_en,
    output logic [1:0]    flags,
    output logic [AW-1:0] rd_src,
    output logic [AW-1:0] wr_src,
    output logic          irq
);
    logic          rd_flag_q, wr_flag_q;
    logic [AW-1:0] rd_src_q, wr_src_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_flag_q <= 1'b0;
            wr_flag_q <= 1'b0;
            rd_src_q  <= '0;
            wr_src_q  <= '0;
        end else begin
            if (clr_mask[0]) rd_flag_q <= 1'b0;
            if (clr_mask[1]) wr_flag_q <= 1'b0;
            if (miss_pulse && !miss_write && (!rd_flag_q || clr_mask[0])) begin
                rd_flag_q <= 1'b1;
                rd_src_q  <= miss_addr;
            end
            if (miss_pulse && miss_write && (!wr_flag_q || clr_mask[1])) begin
                wr_flag_q <= 1'b1;
                wr_src_q  <= miss_addr;
            end
        end
    end

    assign flags  = {wr_flag_q, rd_flag_q};
    assign rd_src = rd_src_q;
    assign wr_src = wr_src_q;
    assign irq    = irq_en && (rd_flag_q || wr_flag_q);

    AST_READ_MISS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_pulse && !miss_write) |=> rd_flag_q); // R9
    AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flag_q && !clr_mask[0]) |=> $stable(rd_src_q)); // R9

endmodule

// File: rtl/awg_scan_fsm.sv
module awg_scan_fsm
    import awg_pkg::*;
#(
    parameter int NUM_WIN = 256,
    parameter int AW      = 36
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [AW-1:0]              req_addr,
    input  logic [31:0]                req_wdata,
    output logic                       req_ready,
    output logic [$clog2(NUM_WIN)-1:0] scan_idx,
    input  logic [AW-13:0]             scan_lo,
    input  logic [AW-13:0]             scan_hi,
    input  logic                       scan_en,
    input  logic [31:0]                fill_value,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [AW-1:0]              mem_addr,
    output logic [31:0]                mem_wdata,
    input  logic [31:0]                mem_rdata,
    output logic                       rsp_valid,
    output logic                       rsp_write,
    output logic                       rsp_hit,
    output logic [31:0]                rsp_rdata,
    output logic                       miss_pulse,
    output logic                       miss_write,
    output logic [AW-1:0]              miss_addr
);
    localparam int IDX_W = $clog2(NUM_WIN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WIN - 1);

    scan_state_e      state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [AW-1:0]    addr_q;
    logic [31:0]      wdata_q, rdata_q;
    logic             write_q, hit_q;
    logic [AW-13:0]   page;
    logic             in_win;

    assign page   = addr_q[AW-1:12];
    assign in_win = scan_en && (page >= scan_lo) && (page < scan_hi);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_SCAN;
            ST_SCAN: begin
                if (in_win)                 state_d = ST_HIT;
                else if (idx_q == LAST_IDX) state_d = ST_MISS;
            end
            ST_HIT:     state_d = write_q ? ST_RESP : ST_MEMWAIT;
            ST_MEMWAIT: state_d = ST_RESP;
            ST_MISS:    state_d = ST_RESP;
            ST_RESP:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // request datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            hit_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    idx_q   <= '0;
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    write_q <= req_write;
                    hit_q   <= 1'b0;
                    rdata_q <= '0;
                end
                ST_SCAN:    if (!in_win && idx_q != LAST_IDX) idx_q <= idx_q + 1'b1;
                ST_HIT:     hit_q   <= 1'b1;
                ST_MEMWAIT: rdata_q <= mem_rdata;
                ST_MISS:    rdata_q <= write_q ? 32'h0 : fill_value;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        mem_req    = (state_q == ST_HIT);
        mem_we     = (state_q == ST_HIT) && write_q;
        rsp_valid  = (state_q == ST_RESP);
        miss_pulse = (state_q == ST_MISS);
    end

    assign scan_idx   = idx_q;
    assign mem_addr   = addr_q;
    assign mem_wdata  = wdata_q;
    assign rsp_write  = write_q;
    assign rsp_hit    = hit_q;
    assign rsp_rdata  = rdata_q;
    assign miss_write = write_q;
    assign miss_addr  = addr_q;

    AST_SINGLE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready)); // R11
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R11

endmodule

// File: rtl/addr_window_guard.sv
module addr_window_guard
    import awg_pkg::*;
#(
    parameter int NUM_WIN = 256,
    parameter int AW      = 36
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr,
    input  logic                         reg_rd,
    input  logic [$clog2(NUM_WIN)+1:0]   reg_addr,
    input  logic [31:0]                  reg_wdata,
    output logic [31:0]                  reg_rdata,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic                         req_write,
    input  logic [AW-1:0]                req_addr,
    input  logic [31:0]                  req_wdata,
    output logic                         rsp_valid,
    output logic                         rsp_write,
    output logic                         rsp_hit,
    output logic [31:0]                  rsp_rdata,
    output logic                         mem_req,
    output logic                         mem_we,
    output logic [AW-1:0]                mem_addr,
    output logic [31:0]                  mem_wdata,
    input  logic [31:0]                  mem_rdata,
    output logic                         irq
);
    localparam int IDX_W     = $clog2(NUM_WIN);
    localparam int PAGE_W    = AW - 12;
    localparam int NUM_WORDS = NUM_WIN / 32;
    localparam int RA_W      = IDX_W + 2;

    reg_region_e      region;
    logic [IDX_W-1:0] ridx;
    logic             ctrl_wr;
    logic [31:0]      fill_q;
    logic             irq_en_q;
    logic [1:0]       clr_mask;
    logic             bit_set, bit_clr, tbl_wr, en_word_wr;
    logic [IDX_W-1:0] scan_idx;
    logic [PAGE_W-1:0] scan_lo, scan_hi, rd_lo, rd_hi;
    logic             scan_en;
    logic [NUM_WIN-1:0] en_flat;
    logic             miss_pulse, miss_write;
    logic [AW-1:0]    miss_addr, rd_src, wr_src;
    logic [1:0]       flags;
    logic [63:0]      rd_src64, wr_src64;
    logic [31:0]      word_rd, rdata_d;

    assign region     = reg_region_e'(reg_addr[RA_W-1 -: 2]);
    assign ridx       = reg_addr[IDX_W-1:0];
    assign ctrl_wr    = reg_wr && (region == RG_CTRL);
    assign tbl_wr     = reg_wr && (region == RG_LOWER || region == RG_UPPER);
    assign en_word_wr = reg_wr && (region == RG_ENABLE) && (int'(ridx) < NUM_WORDS);
    assign bit_set    = ctrl_wr && (int'(ridx) == CT_SET);
    assign bit_clr    = ctrl_wr && (int'(ridx) == CT_CLR);
    assign clr_mask   = (ctrl_wr && int'(ridx) == CT_STATUS) ? reg_wdata[1:0] : 2'b00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q   <= FILL_RESET;
            irq_en_q <= 1'b0;
        end else if (ctrl_wr) begin
            if (int'(ridx) == CT_FILL)  fill_q   <= reg_wdata;
            if (int'(ridx) == CT_IRQEN) irq_en_q <= reg_wdata[0];
        end
    end

    awg_window_table #(.NUM_WIN(NUM_WIN), .PAGE_W(PAGE_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .tbl_wr(tbl_wr), .tbl_sel_upper(region == RG_UPPER),
        .tbl_idx(ridx), .tbl_wpage(reg_wdata[PAGE_W-1:0]),
        .en_word_wr(en_word_wr), .en_word_idx(ridx), .en_word_data(reg_wdata),
        .bit_set(bit_set), .bit_clr(bit_clr), .bit_idx(reg_wdata[IDX_W-1:0]),
        .scan_idx(scan_idx), .scan_lo(scan_lo), .scan_hi(scan_hi), .scan_en(scan_en),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .en_flat(en_flat)
    );

    awg_scan_fsm #(.NUM_WIN(NUM_WIN), .AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .scan_idx(scan_idx), .scan_lo(scan_lo), .scan_hi(scan_hi), .scan_en(scan_en),
        .fill_value(fill_q),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_hit(rsp_hit),
        .rsp_rdata(rsp_rdata),
        .miss_pulse(miss_pulse), .miss_write(miss_write), .miss_addr(miss_addr)
    );

    awg_miss_recorder #(.AW(AW)) u_rec (
        .clk(clk), .rst_n(rst_n),
        .miss_pulse(miss_pulse), .miss_write(miss_write), .miss_addr(miss_addr),
        .clr_mask(clr_mask), .irq_en(irq_en_q),
        .flags(flags), .rd_src(rd_src), .wr_src(wr_src), .irq(irq)
    );

    assign rd_src64 = 64'(rd_src);
    assign wr_src64 = 64'(wr_src);

    always_comb begin
        word_rd = '0;
        for (int w = 0; w < NUM_WORDS; w++)
            if (int'(ridx) == w) word_rd = en_flat[w*32 +: 32];
    end

    always_comb begin
        rdata_d = '0;
        unique case (region)
            RG_LOWER:  rdata_d = 32'(rd_lo);
            RG_UPPER:  rdata_d = 32'(rd_hi);
            RG_ENABLE: rdata_d = word_rd;
            RG_CTRL: begin
                case (int'(ridx))
                    CT_FILL:    rdata_d = fill_q;
                    CT_IRQEN:   rdata_d = {31'h0, irq_en_q};
                    CT_STATUS:  rdata_d = {30'h0, flags};
                    CT_RSRC_LO: rdata_d = rd_src64[31:0];
                    CT_RSRC_HI: rdata_d = rd_src64[63:32];
                    CT_WSRC_LO: rdata_d = wr_src64[31:0];
                    CT_WSRC_HI: rdata_d = wr_src64[63:32];
                    default:    rdata_d = '0;
                endcase
            end
            default: rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rdata_d;
    end

    AST_FILL_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit && !rsp_write && $stable(fill_q)) |-> (rsp_rdata == fill_q)); // R7
    AST_MISS_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        miss_pulse |=> (!mem_req && rsp_valid && !rsp_hit)); // R8

endmodule

// File: tb/tb_addr_window_guard.sv
module tb_addr_window_guard;
    localparam int NUM_WIN = 64;
    localparam int AW      = 36;
    localparam int RA_W    = $clog2(NUM_WIN) + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [RA_W-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic rsp_valid, rsp_write, rsp_hit;
    logic [31:0] rsp_rdata;
    logic mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic irq;

    int total = 0;
    int bad = 0;
    int mem_writes = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    addr_window_guard #(.NUM_WIN(NUM_WIN), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_hit(rsp_hit),
        .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
    );

    // memory model: one-cycle read latency
    logic [31:0] mem_store [logic [AW-1:0]];

    function automatic logic [31:0] mem_value(logic [AW-1:0] a);
        if (mem_store.exists(a)) return mem_store[a];
        return a[31:0] ^ 32'hA5A5_5A5A;
    endfunction

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                mem_store[mem_addr] = mem_wdata;
                mem_writes++;
            end else begin
                mem_rdata <= mem_value(mem_addr);
            end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // scoreboard
    typedef struct {
        bit          write;
        bit          hit;
        logic [31:0] data;
        string       tag;
    } rsp_item_t;
    rsp_item_t sb_q[$];

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R11: actual=unexpected response expected=none");
            end else begin
                rsp_item_t it;
                it = sb_q.pop_front();
                check({it.tag, " hit"}, 32'(rsp_hit), 32'(it.hit));
                check({it.tag, " write"}, 32'(rsp_write), 32'(it.write));
                check({it.tag, " data"}, rsp_rdata, it.data);
            end
        end
    end

    task automatic reg_write(logic [1:0] rg, int idx, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = {rg, 6'(idx)}; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] rg, int idx, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = {rg, 6'(idx)};
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic reg_expect(logic [1:0] rg, int idx, logic [31:0] exp, string tag);
        logic [31:0] v;
        reg_read(rg, idx, v);
        check(tag, v, exp);
    endtask

    task automatic send(bit wr, logic [AW-1:0] a, logic [31:0] wd,
                        bit exp_hit, logic [31:0] exp_d, string tag);
        rsp_item_t it;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        it.write = wr; it.hit = exp_hit; it.data = exp_d; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 busy after accept", 32'(req_ready), 32'h0);
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int wc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 ready", 32'(req_ready), 32'h1);
        check("R1 irq", 32'(irq), 32'h0);
        reg_expect(2'd3, 0, 32'h9292_9292, "R1 fill");
        reg_expect(2'd2, 0, 32'h0, "R1 enable word0");
        reg_expect(2'd2, 1, 32'h0, "R1 enable word1");
        reg_expect(2'd3, 2, 32'h0, "R1 status");

        // window 0: pages 0x100..0x103, still disabled (R12 map)
        reg_write(2'd0, 0, 32'h100);
        reg_write(2'd1, 0, 32'h104);
        reg_write(2'd0, 40, 32'h200);
        reg_write(2'd1, 40, 32'h201);
        reg_write(2'd0, 63, 32'h300);
        reg_write(2'd1, 63, 32'h302);
        reg_expect(2'd1, 0, 32'h104, "R12 upper readback");
        send(0, 36'h0_0010_0010, 0, 0, 32'h9292_9292, "R3 disabled window");
        reg_expect(2'd3, 2, 32'h1, "R9 read flag");
        reg_expect(2'd3, 3, 32'h0010_0010, "R9 read src");
        check("R10 irq masked", 32'(irq), 32'h0);
        reg_write(2'd3, 1, 32'h1);
        @(negedge clk);
        check("R10 irq raised", 32'(irq), 32'h1);
        reg_write(2'd3, 2, 32'h1);
        @(negedge clk);
        check("R10 irq after clear", 32'(irq), 32'h0);
        reg_expect(2'd3, 2, 32'h0, "R9 cleared");

        // enable window 0 by set command
        reg_write(2'd3, 7, 32'd0);
        reg_expect(2'd2, 0, 32'h1, "R4 word0 bit0");
        send(0, 36'h0_0010_0000, 0, 1, 36'h0_0010_0000 ^ 32'hA5A5_5A5A, "R2 lower page");
        send(0, 36'h0_0010_3FFC, 0, 1, 32'h0010_3FFC ^ 32'hA5A5_5A5A, "R6 last page");
        send(0, 36'h0_0010_4000, 0, 0, 32'h9292_9292, "R2 upper exclusive");
        send(0, 36'h0_000F_FFFC, 0, 0, 32'h9292_9292, "R2 below lower");
        reg_write(2'd3, 2, 32'h1);

        // write hit forwarded
        wc = mem_writes;
        send(1, 36'h0_0010_1000, 32'hDEAD_BEEF, 1, 32'h0, "R8 write hit");
        check("R8 write forwarded", 32'(mem_writes - wc), 32'h1);
        send(0, 36'h0_0010_1000, 0, 1, 32'hDEAD_BEEF, "R6 read back");

        // programmable fill
        reg_write(2'd3, 0, 32'h1234_5678);
        send(0, 36'h0_0050_0000, 0, 0, 32'h1234_5678, "R7 new fill");

        // first address kept
        send(0, 36'h0_0060_0000, 0, 0, 32'h1234_5678, "R9 second miss");
        reg_expect(2'd3, 3, 32'h0050_0000, "R9 first read src kept");

        // write miss dropped, high address bits captured
        wc = mem_writes;
        send(1, 36'h9_0020_0000, 32'h1111_1111, 0, 32'h0, "R8 write miss");
        check("R8 write dropped", 32'(mem_writes - wc), 32'h0);
        reg_expect(2'd3, 2, 32'h3, "R9 both flags");
        reg_expect(2'd3, 5, 32'h0020_0000, "R9 write src low");
        reg_expect(2'd3, 6, 32'h9, "R9 write src high");

        // window 40 in word 1
        reg_write(2'd3, 7, 32'd40);
        reg_expect(2'd2, 1, 32'h0000_0100, "R4 word1 bit8");
        send(0, 36'h9_0020_0000, 0, 0, 32'h1234_5678, "R2 high bits differ");
        send(0, 36'h0_0020_0000, 0, 1, 32'h0020_0000 ^ 32'hA5A5_5A5A, "R8 dropped data absent");

        // last window
        reg_write(2'd3, 7, 32'd63);
        send(0, 36'h0_0030_1000, 0, 1, 32'h0030_1000 ^ 32'hA5A5_5A5A, "R2 last window");

        // bit isolation
        reg_write(2'd2, 1, 32'hFFFF_FFFF);
        reg_write(2'd3, 8, 32'd40);
        reg_expect(2'd2, 1, 32'hFFFF_FEFF, "R5 clear one bit");
        reg_expect(2'd2, 0, 32'h1, "R5 other word intact");
        reg_write(2'd2, 1, 32'h0);
        reg_write(2'd3, 8, 32'd0);
        reg_expect(2'd2, 0, 32'h0, "R5 clear bit0");
        send(0, 36'h0_0010_0000, 0, 0, 32'h1234_5678, "R3 re-disabled");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule